// File: doc/BRIEF.md
# Configurable SPI Word Shift Engine

This block is the bit-level engine of a full-duplex SPI master. A single start request moves exactly one word. The engine sends the word out on the data line and, on the same clock edges, collects a word of the same length from the peripheral. Each word follows a configuration byte that sets three things: the clock polarity and phase, the bit order, and where receive data comes from. The source can be the normal input line, a shared bidirectional line, or the engine's own output for loopback.

The word length is programmable from 1 to 32 bits, and a length code of zero means 8 bits. Transmit data is right-justified, so only its low bits are sent. When the transmit data is marked invalid, the engine sends zeros instead, and it still captures receive data. The received word is right-justified, and every bit above the word length reads as zero. The serial clock half-period is the divider value plus one system clocks.

A controller above this block handles chip select, message sequencing and any buffering. It latches the configuration at the start of each word and waits for the one-cycle completion pulse. It can issue the next start in that same cycle.

Top module: `spi_word_engine`

## Requirements
- R1: While idle, `sck` equals mode bit 1 (clock polarity). During a word, `sck` starts at the latched polarity and toggles once every `clk_div`+1 clock cycles, for a total of 2×L toggles, where L is the effective word length.
- R2: Mode bit 0 is the clock phase, so modes 0 to 3 equal {bit1, bit0}. With phase 0, the line is sampled on odd edges (1st, 3rd, ...) and data changes on even edges. With phase 1, data changes on odd edges and is sampled on even edges. Wire bit j is valid on `mosi` before the edge that samples it.
- R3: With mode bit 3 set, the least significant bit of each word goes first. Otherwise the most significant bit (bit L-1) goes first. The same order places received bits.
- R4: A `word_len` of 0 gives L=8. Values 1 to 32 give L equal to the value, and larger values give L=32.
- R5: If `tx_valid` is low when the start is accepted, the engine sends zeros for the whole word and still captures receive data.
- R6: Only the low L bits of `tx_word` are sent. `rx_word` is right-justified with bits L and above at zero. It changes only in the cycle `done` is high and holds otherwise.
- R7: `done` is high for exactly one cycle, 2×L×(`clk_div`+1) cycles after the cycle in which the start was accepted. In that cycle `busy` is low and `sck` is back at the polarity level.
- R8: With mode bit 4 set, received bits come from `sdio_in` and `miso` is ignored. If `rx_dir` was high at start, `mosi_oe` is low and `mosi` is 0 for the word. Otherwise `mosi_oe` is high. The direction is held until the next start.
- R9: With mode bit 5 set, the received word equals the transmitted bits, and `miso` and `sdio_in` are ignored.
- R10: A start while `busy` is high is ignored: the word in progress and its data are unaffected. A start in the `done` cycle is accepted.
- R11: In reset, `busy`, `done`, `mosi` and `rx_word` are 0, `mosi_oe` is 1, and `sck` follows mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to shift one word; taken when idle |
| tx_word | input | 32 | Right-justified transmit word |
| tx_valid | input | 1 | Transmit data present; low sends zeros |
| word_len | input | 6 | Word length code (0 means 8) |
| clk_div | input | 8 | Serial clock half-period minus one, in clocks |
| mode | input | 8 | Phase, polarity, LSB-first, shared line, loopback |
| rx_dir | input | 1 | Shared-line direction: 1 receive, 0 transmit |
| miso | input | 1 | Serial input line |
| sdio_in | input | 1 | Input side of the shared data pad |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output data |
| mosi_oe | output | 1 | Output enable for the data pad |
| rx_word | output | 32 | Right-justified received word |
| done | output | 1 | One-cycle word-complete pulse |
| busy | output | 1 | Word in progress |

## Verification
The completion of one word and the acceptance of the next start can fall in the same cycle. The bench provokes this by issuing each new start in exactly the `done` cycle of the previous word, so most words run back to back. It then checks that the following word loads its own length, mode and data, with no idle gap on `sck`, and that the finished word's `rx_word` stays intact. The bench also pulses start with different data in the middle of a word and expects every output to follow the original word cycle for cycle.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int MB_CPHA = 0;
  localparam int MB_CPOL = 1;
  localparam int MB_LSB  = 3;
  localparam int MB_3W   = 4;
  localparam int MB_LOOP = 5;

  typedef struct packed {
    logic loop;
    logic three;
    logic rx_dir;
    logic lsb;
    logic cpol;
    logic cpha;
  } cfg_t;

  // Effective word length from the raw code: zero means a byte, clamp at maxw.
  function automatic int eff_len(input int raw, input int maxw);
    if (raw == 0) return (maxw < 8) ? maxw : 8;
    if (raw > maxw) return maxw;
    return raw;
  endfunction

  // Wire bit index on the line after 'edges' clock edges of the word.
  function automatic int bit_slot(input int edges, input logic cpha);
    if (cpha && edges > 0) return (edges - 1) / 2;
    return edges / 2;
  endfunction

  // Word bit position carried by wire slot 'slot'.
  function automatic int word_pos(input int slot, input int len, input logic lsb);
    return lsb ? slot : (len - 1 - slot);
  endfunction

endpackage

// File: rtl/spi_eng_tick.sv
module spi_eng_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
    end
  end

  // R1: half-period counter never passes the latched divider
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_q));

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W + 1),
  parameter int CNT_W  = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_valid,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [7:0]        mode,
  input  logic              rx_dir,
  input  logic              tick,
  input  logic              rx_src,
  output logic              load,
  output logic              busy,
  output cfg_t              cfg,
  output logic              tx_bit,
  output logic              sck,
  output logic [DATA_W-1:0] rx_word,
  output logic              done
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  function automatic logic [DATA_W-1:0] low_mask(input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  logic              busy_q, done_q;
  cfg_t              cfg_q;
  logic [LEN_W-1:0]  len_q, len_eff;
  logic [DATA_W-1:0] tx_q, acc_q, acc_nxt, rx_q;
  logic [CNT_W-1:0]  e_q, next_e;
  logic [IDX_W-1:0]  tx_pos, rx_pos;
  logic              sample_now, last_edge;

  assign load       = start && !busy_q;
  assign len_eff    = LEN_W'(eff_len(int'(word_len), DATA_W));
  assign next_e     = e_q + CNT_W'(1);
  assign sample_now = busy_q && tick && (next_e[0] ^ cfg_q.cpha);
  assign last_edge  = busy_q && tick && (next_e == {len_q, 1'b0});
  assign tx_pos     = IDX_W'(word_pos(bit_slot(int'(e_q), cfg_q.cpha), int'(len_q), cfg_q.lsb));
  assign rx_pos     = IDX_W'(word_pos(int'(e_q >> 1), int'(len_q), cfg_q.lsb));
  assign tx_bit     = busy_q && tx_q[tx_pos];

  always_comb begin
    acc_nxt = acc_q;
    if (sample_now) acc_nxt[rx_pos] = rx_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cfg_q  <= '0;
      len_q  <= '0;
      tx_q   <= '0;
      acc_q  <= '0;
      rx_q   <= '0;
      e_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        cfg_q  <= '{loop: mode[MB_LOOP], three: mode[MB_3W], rx_dir: rx_dir,
                    lsb: mode[MB_LSB], cpol: mode[MB_CPOL], cpha: mode[MB_CPHA]};
        len_q  <= len_eff;
        tx_q   <= tx_valid ? (tx_word & low_mask(len_eff)) : '0;
        acc_q  <= '0;
        e_q    <= '0;
      end else if (busy_q && tick) begin
        e_q   <= next_e;
        acc_q <= acc_nxt;
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= acc_nxt;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign cfg     = cfg_q;
  assign rx_word = rx_q;
  assign sck     = busy_q ? (cfg_q.cpol ^ e_q[0]) : mode[MB_CPOL];

  // R7: completion only ends a running word
  p_done_ends_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));
  // R7: edge count stays inside the word
  p_edge_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (e_q < {len_q, 1'b0}));
  // R10: transmit data not reloaded while a word runs
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(tx_q));
  // R6: bits above the word length read zero
  p_rx_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((rx_q & ~low_mask(len_q)) == '0));

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_valid,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [7:0]        mode,
  input  logic              rx_dir,
  input  logic              miso,
  input  logic              sdio_in,
  output logic              sck,
  output logic              mosi,
  output logic              mosi_oe,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              busy
);
  logic load, tick, tx_bit, rx_src;
  cfg_t cfg;

  spi_eng_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .load(load), .div(clk_div), .tick(tick)
  );

  spi_eng_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .tx_valid(tx_valid),
    .word_len(word_len), .mode(mode), .rx_dir(rx_dir), .tick(tick), .rx_src(rx_src),
    .load(load), .busy(busy), .cfg(cfg), .tx_bit(tx_bit), .sck(sck),
    .rx_word(rx_word), .done(done)
  );

  // Receive source: own bits in loopback, shared pad in 3-wire, else miso.
  always_comb begin
    if (cfg.loop)       rx_src = tx_bit;
    else if (cfg.three) rx_src = sdio_in;
    else                rx_src = miso;
  end

  assign mosi_oe = !(cfg.three && cfg.rx_dir);
  assign mosi    = mosi_oe && tx_bit;

  // R1: serial clock only moves on a half-period tick
  p_sck_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sck));
  // R2: output data only moves on a half-period tick
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(mosi));

endmodule

// File: tb/spi_word_engine_tb.sv
module spi_word_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic        tx_valid = 1'b0;
  logic [5:0]  word_len = '0;
  logic [7:0]  clk_div = '0;
  logic [7:0]  mode = 8'h02;
  logic        rx_dir = 1'b0;
  logic        miso = 1'b0;
  logic        sdio_in = 1'b0;
  logic        sck, mosi, mosi_oe, done, busy;
  logic [31:0] rx_word;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_rx = '0;
  logic        oe_m = 1'b1;

  always #4 clk = ~clk;

  spi_word_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .tx_valid(tx_valid),
    .word_len(word_len), .clk_div(clk_div), .mode(mode), .rx_dir(rx_dir),
    .miso(miso), .sdio_in(sdio_in), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe),
    .rx_word(rx_word), .done(done), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] msk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  function automatic logic wbit(input logic [31:0] w, input int j, input int len, input logic lsb);
    return lsb ? w[j] : w[len-1-j];
  endfunction

  task automatic idle(input int n, input logic [7:0] md);
    mode = md;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 idle sck", {31'b0, sck}, {31'b0, md[1]});
      chk("R7 idle done", {31'b0, done}, 32'h0);
      chk("R10 idle busy", {31'b0, busy}, 32'h0);
      chk("R2 idle mosi", {31'b0, mosi}, 32'h0);
      chk("R8 idle oe", {31'b0, mosi_oe}, {31'b0, oe_m});
      chk("R6 idle rx hold", rx_word, exp_rx);
    end
  endtask

  // Called at a negedge; returns at the negedge of the done cycle.
  task automatic run_word(input logic [31:0] tx, input logic v, input int lraw, input int dv,
                          input logic [7:0] md, input logic dir, input logic [31:0] slave,
                          input logic poke, input string tag);
    int len, h, e, j, last;
    logic [31:0] txm, rxe;
    logic cpol, cpha, lsb, tw, lp, mb, sb, rxmode;
    len  = (lraw == 0) ? 8 : ((lraw > 32) ? 32 : lraw);
    h    = dv + 1;
    cpol = md[1]; cpha = md[0]; lsb = md[3]; tw = md[4]; lp = md[5];
    rxmode = tw && dir;
    txm  = v ? (tx & msk(len)) : 32'h0;
    if (lp || (tw && !dir)) rxe = txm;
    else rxe = slave & msk(len);
    tx_word = tx; tx_valid = v; word_len = 6'(lraw); clk_div = 8'(dv);
    mode = md; rx_dir = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oe_m = !rxmode;
    last = 2 * len * h;
    for (int c = 0; c <= last; c++) begin
      if (c < last) begin
        e  = c / h;
        j  = (cpha && e > 0) ? (e - 1) / 2 : e / 2;
        mb = wbit(txm, j, len, lsb);
        sb = wbit(slave, j, len, lsb);
        chk({tag, " R1 sck"}, {31'b0, sck}, {31'b0, cpol ^ e[0]});
        chk({tag, " R2 mosi"}, {31'b0, mosi}, {31'b0, rxmode ? 1'b0 : mb});
        chk({tag, " R7 done low"}, {31'b0, done}, 32'h0);
        chk({tag, " R10 busy"}, {31'b0, busy}, 32'h1);
        chk({tag, " R8 oe"}, {31'b0, mosi_oe}, {31'b0, oe_m});
        chk({tag, " R6 rx hold"}, rx_word, exp_rx);
        if (lp)            begin miso = ~mb; sdio_in = ~mb; end
        else if (rxmode)   begin miso = ~sb; sdio_in = sb;  end
        else if (tw)       begin miso = ~mb; sdio_in = mb;  end
        else               begin miso = sb;  sdio_in = ~sb; end
        if (poke && c == 2) begin start = 1'b1; tx_word = ~tx; end
        if (poke && c == 3) start = 1'b0;
        @(negedge clk);
      end else begin
        exp_rx = rxe;
        chk({tag, " R7 done"}, {31'b0, done}, 32'h1);
        chk({tag, " R7 sck home"}, {31'b0, sck}, {31'b0, cpol});
        chk({tag, " R10 busy low"}, {31'b0, busy}, 32'h0);
        chk({tag, " R2 mosi idle"}, {31'b0, mosi}, 32'h0);
        chk({tag, " rx word"}, rx_word, rxe);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R11: reset state
    chk("R11 sck", {31'b0, sck}, 32'h1);
    chk("R11 mosi", {31'b0, mosi}, 32'h0);
    chk("R11 oe", {31'b0, mosi_oe}, 32'h1);
    chk("R11 done", {31'b0, done}, 32'h0);
    chk("R11 busy", {31'b0, busy}, 32'h0);
    chk("R11 rx", rx_word, 32'h0);
    rst_n = 1'b1;
    idle(3, 8'h00);
    run_word(32'h0000_00A5, 1'b1, 0, 1, 8'h00, 1'b0, 32'h0000_003C, 1'b0, "R4 len0 mode0");
    run_word(32'hFFFF_FABC, 1'b1, 12, 0, 8'h01, 1'b0, 32'hFFFF_F5A3, 1'b0, "R2 mode1 len12");
    run_word(32'h0000_8D31, 1'b1, 16, 2, 8'h0A, 1'b0, 32'h0000_4E27, 1'b0, "R3 lsb mode2");
    run_word(32'hDEAD_BEEF, 1'b1, 32, 0, 8'h03, 1'b0, 32'h1234_5678, 1'b1, "R10 poke mode3");
    idle(4, 8'h02);
    run_word(32'hFFFF_FFFF, 1'b0, 10, 1, 8'h00, 1'b0, 32'h0000_02AB, 1'b0, "R5 zeros");
    run_word(32'h0000_0135, 1'b1, 9, 1, 8'h21, 1'b0, 32'h0000_00FF, 1'b0, "R9 loop");
    run_word(32'h0000_00C3, 1'b1, 8, 0, 8'h10, 1'b1, 32'h0000_0096, 1'b0, "R8 3w rx");
    idle(3, 8'h00);
    run_word(32'h0000_0016, 1'b1, 5, 1, 8'h11, 1'b0, 32'h0000_0009, 1'b0, "R8 3w tx");
    run_word(32'h0000_0001, 1'b1, 1, 0, 8'h02, 1'b0, 32'h0000_0001, 1'b0, "R4 len1");
    run_word(32'h8000_0001, 1'b1, 40, 0, 8'h08, 1'b0, 32'h7F00_00FE, 1'b0, "R4 clamp");
    idle(4, 8'h02);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule